// File: doc/BRIEF.md
# Video Memory Word Access Port

This block gives a CPU a byte-wide path into a word-organised video memory of 16-bit words that sits inside the block. The CPU first sets a configuration byte. It then writes a word address as two separate bytes and moves data through separate low-byte and high-byte registers. After each access the address can step forward by itself. The configuration picks the step size. It also picks whether the low-byte or the high-byte access moves the address, so a stream of single bytes or of whole words can be moved with no re-addressing between them.

Reads go through a one-word prefetch register. Writing either address byte loads the addressed word into it at once. A read returns a byte of the prefetch register one cycle later on `rdata`. When the read is the one that moves the address, the prefetch register is reloaded from the current address before the address steps. The byte the caller gets is always the byte that was buffered before the read. The configuration also holds a two-bit address-remap code. It is stored, but every code addresses the memory with the plain address.

Top module: `vram_word_port`

## Requirements
- R1: After reset the word address, the prefetch word and `rdata` are all zero. The configuration is zero, which means step 1 with low-byte trigger.
- R2: A write with `sel`=0 loads the configuration. Bits 1:0 give the address step: code 0 steps by 1, code 1 by 32, and codes 2 and 3 both by 128. A configuration write changes neither the address nor the prefetch word.
- R3: Configuration bit 7 names the trigger access. When it is 0, low-byte data accesses (`sel`=3) advance the address. When it is 1, high-byte data accesses (`sel`=4) advance it.
- R4: A write with `sel`=1 replaces address bits 7:0, and a write with `sel`=2 replaces address bits 15:8. Either write loads the memory word at the resulting address into the prefetch word in the same cycle.
- R5: A data write with `sel`=3 stores `wdata` into bits 7:0 of the addressed word. A data write with `sel`=4 stores it into bits 15:8. The other byte is kept, and the prefetch word is not changed. The address advances only when the write is the trigger access.
- R6: A read with `sel`=3 puts prefetch bits 7:0 on `rdata` after the clock edge. A read with `sel`=4 puts bits 15:8 there. At all other times `rdata` holds its value.
- R7: A trigger read returns the byte that was buffered before the read. It reloads the prefetch word from the current address, and only after that does the address advance by the step.
- R8: A non-trigger read changes neither the prefetch word nor the address.
- R9: The word address is ADDR_W bits wide. Address bits at or above ADDR_W that are written through `sel`=2 are dropped, and stepping past the top of memory wraps to the bottom.
- R10: Configuration bits 3:2 hold a remap code. Every value of this code addresses the memory with the unmodified address.
- R11: When `wr_en` and `rd_en` are both high in one cycle, the write takes effect and the read is ignored, so `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Register select: 0 config, 1 address low, 2 address high, 3 data low, 4 data high |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected data register |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte returned by the most recent data read |

## Verification
The bench builds the port with ADDR_W set to 9, which gives 512 words. With this size, a 128-word step runs off the top of memory within a few accesses. An address high byte with bits above bit 8 set shows that the excess bits are dropped. Walking the table with each step code and both trigger choices shows the stale first word that the prefetch gives after re-addressing, and shows that non-trigger reads leave the buffer alone. Directed cases cover the reset values and the case where a write and a read arrive in the same cycle.

// File: rtl/vport_pkg.sv
package vport_pkg;

    typedef enum logic [2:0] {
        SEL_CFG     = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_ADDR_HI = 3'd2,
        SEL_DATA_LO = 3'd3,
        SEL_DATA_HI = 3'd4
    } port_sel_e;

    typedef struct packed {
        logic       trig_hi;
        logic [1:0] remap;
        logic [1:0] step_code;
    } port_cfg_t;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned STEP_MID = 32;
    localparam int unsigned STEP_BIG = 128;

endpackage

// File: rtl/vport_step_dec.sv
module vport_step_dec #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [1:0]        step_code,
    output logic [ADDR_W-1:0] step
);
    import vport_pkg::*;

    always_comb begin
        case (step_code)
            2'd0:    step = ADDR_W'(1);
            2'd1:    step = ADDR_W'(STEP_MID);
            default: step = ADDR_W'(STEP_BIG);
        endcase
    end

endmodule

// File: rtl/vport_word_mem.sv
module vport_word_mem #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic                        clk,
    input  logic                        we_lo,
    input  logic                        we_hi,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [vport_pkg::BYTE_W-1:0] wbyte,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [vport_pkg::WORD_W-1:0] rword
);
    import vport_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_lo) mem_q[waddr][BYTE_W-1:0]      <= wbyte;
        if (we_hi) mem_q[waddr][WORD_W-1:BYTE_W] <= wbyte;
    end

    assign rword = mem_q[raddr];

endmodule

// File: rtl/vport_core.sv
module vport_core #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   sel,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [vport_pkg::BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]            step,
    input  logic [vport_pkg::WORD_W-1:0] rword,
    output logic [1:0]                   step_code,
    output logic [ADDR_W-1:0]            mem_raddr,
    output logic [ADDR_W-1:0]            mem_waddr,
    output logic                         mem_we_lo,
    output logic                         mem_we_hi,
    output logic [vport_pkg::BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [vport_pkg::WORD_W-1:0] pref_word,
    output logic                         trig_hi
);
    import vport_pkg::*;

    localparam int unsigned FULL_W = 2 * BYTE_W;

    typedef struct packed {
        port_cfg_t          cfg;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  pref;
        logic [BYTE_W-1:0]  rdata;
    } state_t;

    state_t st_d, st_q;

    // Remap hook: every code selects the plain address.
    function automatic logic [ADDR_W-1:0] map_addr(input logic [1:0] code,
                                                   input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        case (code)
            2'd0:    r = a;
            default: r = a;
        endcase
        return r;
    endfunction

    logic [FULL_W-1:0] addr_wide;
    logic [FULL_W-1:0] addr_new;
    logic              lo_is_trig;
    logic              hi_is_trig;

    always_comb begin
        st_d       = st_q;
        mem_we_lo  = 1'b0;
        mem_we_hi  = 1'b0;
        addr_wide  = FULL_W'(st_q.addr);
        addr_new   = addr_wide;
        lo_is_trig = !st_q.cfg.trig_hi;
        hi_is_trig = st_q.cfg.trig_hi;
        mem_waddr  = map_addr(st_q.cfg.remap, st_q.addr);
        mem_raddr  = map_addr(st_q.cfg.remap, st_q.addr);

        if (wr_en) begin
            case (sel)
                SEL_CFG: begin
                    st_d.cfg.trig_hi   = wdata[7];
                    st_d.cfg.remap     = wdata[3:2];
                    st_d.cfg.step_code = wdata[1:0];
                end
                SEL_ADDR_LO: begin
                    addr_new  = {addr_wide[FULL_W-1:BYTE_W], wdata};
                    st_d.addr = addr_new[ADDR_W-1:0];
                    mem_raddr = map_addr(st_q.cfg.remap, st_d.addr);
                    st_d.pref = rword;
                end
                SEL_ADDR_HI: begin
                    addr_new  = {wdata, addr_wide[BYTE_W-1:0]};
                    st_d.addr = addr_new[ADDR_W-1:0];
                    mem_raddr = map_addr(st_q.cfg.remap, st_d.addr);
                    st_d.pref = rword;
                end
                SEL_DATA_LO: begin
                    mem_we_lo = 1'b1;
                    if (lo_is_trig) st_d.addr = st_q.addr + step;
                end
                SEL_DATA_HI: begin
                    mem_we_hi = 1'b1;
                    if (hi_is_trig) st_d.addr = st_q.addr + step;
                end
                default: ;
            endcase
        end else if (rd_en) begin
            case (sel)
                SEL_DATA_LO: begin
                    st_d.rdata = st_q.pref[BYTE_W-1:0];
                    if (lo_is_trig) begin
                        st_d.pref = rword;
                        st_d.addr = st_q.addr + step;
                    end
                end
                SEL_DATA_HI: begin
                    st_d.rdata = st_q.pref[WORD_W-1:BYTE_W];
                    if (hi_is_trig) begin
                        st_d.pref = rword;
                        st_d.addr = st_q.addr + step;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_code = st_q.cfg.step_code;
    assign rdata     = st_q.rdata;
    assign cur_addr  = st_q.addr;
    assign pref_word = st_q.pref;
    assign trig_hi   = st_q.cfg.trig_hi;

endmodule

// File: rtl/vram_word_port.sv
module vram_word_port #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    import vport_pkg::*;

    logic [1:0]        step_code;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] mem_raddr;
    logic [ADDR_W-1:0] mem_waddr;
    logic              mem_we_lo;
    logic              mem_we_hi;
    logic [WORD_W-1:0] rword;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] pref_word;
    logic              trig_hi;

    vport_step_dec #(.ADDR_W(ADDR_W)) u_step (
        .step_code (step_code),
        .step      (step)
    );

    vport_word_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we_lo (mem_we_lo),
        .we_hi (mem_we_hi),
        .waddr (mem_waddr),
        .wbyte (wdata),
        .raddr (mem_raddr),
        .rword (rword)
    );

    vport_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .step      (step),
        .rword     (rword),
        .step_code (step_code),
        .mem_raddr (mem_raddr),
        .mem_waddr (mem_waddr),
        .mem_we_lo (mem_we_lo),
        .mem_we_hi (mem_we_hi),
        .rdata     (rdata),
        .cur_addr  (cur_addr),
        .pref_word (pref_word),
        .trig_hi   (trig_hi)
    );

endmodule

// File: rtl/vport_checker.sv
module vport_checker #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [15:0]       pref_word,
    input logic [ADDR_W-1:0] step,
    input logic              trig_hi
);
    logic rd_only;
    logic data_sel;
    assign rd_only  = rd_en && !wr_en;
    assign data_sel = (sel == 3'd3) || (sel == 3'd4);

    p_step_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ADDR_W'(1)) || (step == ADDR_W'(32)) || (step == ADDR_W'(128)));

    p_cfg_keeps_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd0) |=> ($stable(cur_addr) && $stable(pref_word)));

    p_data_wr_keeps_pref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && data_sel) |=> $stable(pref_word));

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_only && data_sel) |=> $stable(rdata));

    p_lo_read_old_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && sel == 3'd3) |=> (rdata == $past(pref_word[7:0])));

    p_hi_read_old_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && sel == 3'd4) |=> (rdata == $past(pref_word[15:8])));

    p_quiet_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && ((sel == 3'd3 && trig_hi) || (sel == 3'd4 && !trig_hi)))
        |=> ($stable(cur_addr) && $stable(pref_word)));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> $stable(rdata));

endmodule

bind vram_word_port vport_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .cur_addr  (cur_addr),
    .pref_word (pref_word),
    .step      (step),
    .trig_hi   (trig_hi)
);

// File: tb/vram_word_port_test.sv
module vram_word_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    vram_word_port #(.ADDR_W(9)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    // entry: bit 11 = read, bits 10:8 = sel, bits 7:0 = write byte or expected byte
    localparam int NV = 61;
    localparam logic [11:0] VEC [NV] = '{
        // R2/R3/R4/R5: step 1, low trigger, words at 0x010..0x012
        12'h000, 12'h110, 12'h200,
        12'h4A1, 12'h311, 12'h4A2, 12'h322, 12'h4A3, 12'h333,
        12'h110,
        // R7/R8: first word read twice after re-address
        12'hCA1, 12'hB11, 12'hCA1, 12'hB11, 12'hCA2, 12'hB22, 12'hCA3,
        // R2/R3: step 32, high trigger at 0x100
        12'h081, 12'h100, 12'h201,
        12'h344, 12'h4B4, 12'h355, 12'h4B5,
        12'h100,
        12'hB44, 12'hCB4, 12'hCB4, 12'hB55,
        // R2/R9: code 2 step 128 wraps 0x180 -> 0x000
        12'h002, 12'h201, 12'h180,
        12'h4C6, 12'h366, 12'h4C7, 12'h377,
        // code 3 also steps 128
        12'h003,
        12'h4C8, 12'h388,
        12'h200, 12'h100,
        12'hCC7, 12'hB77, 12'hB77, 12'hCC8, 12'hB88, 12'hCB4, 12'hB44, 12'hCC6, 12'hB66, 12'hCC7,
        // R9: high address bits above bit 8 dropped
        12'h203, 12'h120,
        12'hCB5,
        // R10: remap code 3 still plain addressing
        12'h00C, 12'h110, 12'h200,
        12'hCA1, 12'hB11, 12'hB11, 12'hCA2
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic access(input logic is_rd, input logic both, input logic [2:0] s,
                          input logic [7:0] d);
        @(negedge clk);
        sel   = s;
        wdata = d;
        wr_en = !is_rd || both;
        rd_en = is_rd || both;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", rdata, 8'h00);
        access(1'b1, 1'b0, 3'd4, 8'h00);
        check("R1 prefetch high byte after reset", rdata, 8'h00);
        access(1'b1, 1'b0, 3'd3, 8'h00);
        check("R1 prefetch low byte after reset", rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][11], 1'b0, VEC[i][10:8], VEC[i][7:0]);
            if (VEC[i][11])
                check($sformatf("R6/R7 table entry %0d", i), rdata, VEC[i][7:0]);
        end

        // R11: write and read together at 0x030, the write wins
        access(1'b0, 1'b0, 3'd1, 8'h30);
        held = rdata;
        access(1'b0, 1'b1, 3'd4, 8'hDD);
        check("R11 rdata held on write+read", rdata, held);
        access(1'b0, 1'b1, 3'd3, 8'h3E);
        check("R11 rdata held on second write+read", rdata, held);
        access(1'b0, 1'b0, 3'd1, 8'h30);
        access(1'b1, 1'b0, 3'd4, 8'h00);
        check("R5 high lane stored", rdata, 8'hDD);
        access(1'b1, 1'b0, 3'd3, 8'h00);
        check("R5 low lane stored", rdata, 8'h3E);

        finish_run();
    end

endmodule